// File: doc/BRIEF.md
# Serial Layered Min-Sum Check-Node Unit

This block is the check-node engine of a layered LDPC decoder. It works on one parity check at a time and takes one edge per clock. For each edge it reads the current LLR of the connected variable and rebuilds that check's previous message to that variable. It subtracts the old message from the LLR to form the variable-to-check value, and it tracks the smallest and second-smallest magnitudes as the values arrive. When every edge of the check has been seen, a second pass replays the delayed values in edge order. For each edge it emits a fresh check message and an updated LLR, and it writes both back so that the next check in the layer order works on the refreshed LLRs.

Old check messages are not stored at full width. Each check keeps two magnitudes, and each edge keeps a 2-bit code, both in on-chip RAM. LLRs and check magnitudes share one W-bit dual-port memory. The caller supplies the check index, its degree, a first-iteration flag and the stream of variable addresses. Matrix addressing lives outside the block.

Top module: `layered_cn_unit`

## Requirements
- R1: After reset, `ready` is 1 and both `out_valid` and `done` are 0.
- R2: Each edge's variable-to-check value q is the stored LLR minus the old message, saturated to [-31, 31]. The old message is 0 when `first_iter` was set at `cn_start`. Otherwise the old message is rebuilt from the check's stored pair and the edge's 2-bit code: bit 0 = 1 takes the second magnitude and 0 takes the first; bit 1 = 1 makes the message negative.
- R3: The first magnitude is the smallest |q| and the second is the next smallest; equal values count separately. The selected edge is the lowest edge position holding the smallest value. That edge receives the second magnitude, and every other edge receives the first.
- R4: The sign of an emitted message is the XOR of the signs of every q in the check except the edge's own q, where a sign is 1 when q < 0. `out_code` = {sign, selected-edge flag}.
- R5: `out_llr` equals q + `out_msg`, saturated to [-31, 31]. That value is written back to the variable's LLR and is read by any later check that uses the variable.
- R6: Outputs appear for the edges in the order they were accepted, on `deg` consecutive cycles. The first output comes two cycles after the last edge is accepted. `done` is high with the last one, and `ready` returns on the following cycle.
- R7: While `ready` is 0, `cn_start` is ignored. In the input phase, a cycle with `edge_valid` low accepts no edge.
- R8: On a later iteration the old message rebuilt from the stored pair and the stored code equals the message emitted for that edge on the previous pass.
- R9: Neither `out_msg` nor `out_llr` ever takes the value -32.
- R10: The degree is taken at run time for each check and may be any value from 2 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write a channel LLR (honoured only when idle and no `cn_start`) |
| ld_addr | input | 6 | Variable address for the load |
| ld_llr | input | 6 | Channel LLR, two's complement |
| cn_start | input | 1 | Begin a check node (honoured only when `ready`) |
| cn_id | input | 4 | Check-node index |
| cn_deg | input | 5 | Check-node degree, 2 to 16 |
| first_iter | input | 1 | Treat old messages as zero |
| edge_valid | input | 1 | An edge address is presented |
| edge_var | input | 6 | Variable address of the edge |
| ready | output | 1 | Idle, can accept `cn_start` |
| out_valid | output | 1 | Output pass active |
| out_var | output | 6 | Variable address of the output edge |
| out_msg | output | 6 | New check message, two's complement |
| out_llr | output | 6 | Updated LLR |
| out_code | output | 2 | Stored code {sign, selects second magnitude} |
| done | output | 1 | Last edge of the check node |

## Verification
The hardest conditions to reach are the boundary cases of the magnitude tracking and of the saturation. One is a tie where the smallest magnitude appears twice. Another is a sum that runs past either rail, which only happens when the other signs in the check line up. The bench loads dedicated LLR groups that hit those cases on the first pass. It then repeats every check on a second pass, so the compressed messages written earlier are rebuilt and subtracted, and neighbouring checks that share variables see each other's write-backs. One check contains a stall cycle, and during that stall a stray `cn_start` is driven.

// File: rtl/layered_cn_unit.sv
module layered_cn_unit #(
  parameter int W    = 6,
  parameter int NV   = 64,
  parameter int NC   = 16,
  parameter int DMAX = 16
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [$clog2(NV)-1:0]    ld_addr,
  input  logic [W-1:0]             ld_llr,
  input  logic                     cn_start,
  input  logic [$clog2(NC)-1:0]    cn_id,
  input  logic [$clog2(DMAX+1)-1:0] cn_deg,
  input  logic                     first_iter,
  input  logic                     edge_valid,
  input  logic [$clog2(NV)-1:0]    edge_var,
  output logic                     ready,
  output logic                     out_valid,
  output logic [$clog2(NV)-1:0]    out_var,
  output logic [W-1:0]             out_msg,
  output logic [W-1:0]             out_llr,
  output logic [1:0]               out_code,
  output logic                     done
);
  localparam int AW    = $clog2(NV);
  localparam int CW    = $clog2(NC);
  localparam int DW    = $clog2(DMAX+1);
  localparam int PW    = $clog2(DMAX);
  localparam int MW    = W-1;
  localparam int DEPTH = NV + 2*NC;
  localparam int MAW   = $clog2(DEPTH);
  localparam int EW    = CW + PW;
  localparam int LIMI  = 2**(W-1) - 1;

  typedef enum logic [1:0] {S_IDLE, S_IN, S_OUT} st_t;

  function automatic logic [W-1:0] sat(input logic signed [W:0] x);
    if (x > $signed((W+1)'(LIMI)))       return W'(LIMI);
    else if (x < -$signed((W+1)'(LIMI))) return W'(-LIMI);
    else                                 return x[W-1:0];
  endfunction

  function automatic logic [MAW-1:0] magaddr(input logic [CW-1:0] c, input logic s);
    return MAW'(NV + 2*int'(c) + int'(s));
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [1:0]   cmem [2**EW];
  logic [W-1:0] rd_a, rd_b;
  logic [1:0]   rd_c;
  logic           a_we, b_we, c_we;
  logic [MAW-1:0] a_addr, b_addr;
  logic [W-1:0]   a_wd, b_wd;
  logic [EW-1:0]  c_waddr, c_raddr;
  logic [1:0]     c_wd;

  st_t            st;
  logic [CW-1:0]  cid;
  logic [DW-1:0]  deg, in_cnt;
  logic           first, pf, p_v;
  logic [PW-1:0]  p_pos, out_cnt, idx;
  logic [AW-1:0]  p_addr;
  logic [MW-1:0]  min1, min2;
  logic           sx;
  logic [W-1:0]   om1, om2;
  logic [W-1:0]   dq [DMAX];
  logic [AW-1:0]  da [DMAX];

  wire acc = (st == S_IN) && edge_valid && (in_cnt < deg);

  wire [W-1:0]  omw  = rd_c[0] ? om2 : om1;
  wire [W-1:0]  oldm = first ? '0 : (rd_c[1] ? -omw : omw);
  wire [W-1:0]  qn   = sat($signed({rd_b[W-1], rd_b}) - $signed({oldm[W-1], oldm}));
  wire [W-1:0]  qneg = -qn;
  wire [MW-1:0] qmag = qn[W-1] ? qneg[MW-1:0] : qn[MW-1:0];

  wire [W-1:0]  dcur = dq[out_cnt];
  wire          sel2 = (out_cnt == idx);
  wire [MW-1:0] rmag = sel2 ? min2 : min1;
  wire          rsg  = sx ^ dcur[W-1];
  wire [W-1:0]  rpos = {1'b0, rmag};
  wire [W-1:0]  rmsg = rsg ? -rpos : rpos;
  wire [W-1:0]  nl   = sat($signed({dcur[W-1], dcur}) + $signed({rmsg[W-1], rmsg}));
  wire          last_out = (DW'(out_cnt) + 1'b1 == deg);

  always_comb begin
    a_we   = 1'b0;
    a_addr = MAW'(ld_addr);
    a_wd   = ld_llr;
    b_we   = 1'b0;
    b_addr = MAW'(edge_var);
    b_wd   = {1'b0, min1};
    case (st)
      S_IDLE: begin
        if (cn_start) begin
          a_addr = magaddr(cn_id, 1'b0);
          b_addr = magaddr(cn_id, 1'b1);
        end else if (ld_en) begin
          a_we = 1'b1;
        end
      end
      S_OUT: begin
        a_we   = 1'b1;
        a_addr = MAW'(da[out_cnt]);
        a_wd   = nl;
        if (out_cnt == '0) begin
          b_we = 1'b1; b_addr = magaddr(cid, 1'b0); b_wd = {1'b0, min1};
        end else if (out_cnt == PW'(1)) begin
          b_we = 1'b1; b_addr = magaddr(cid, 1'b1); b_wd = {1'b0, min2};
        end
      end
      default: ;
    endcase
  end

  assign c_we    = (st == S_OUT);
  assign c_waddr = {cid, out_cnt};
  assign c_wd    = {rsg, sel2};
  assign c_raddr = {cid, in_cnt[PW-1:0]};

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd; else rd_a <= mem[a_addr];
    if (b_we) mem[b_addr] <= b_wd; else rd_b <= mem[b_addr];
    if (c_we) cmem[c_waddr] <= c_wd;
    rd_c <= cmem[c_raddr];
  end

  always_ff @(posedge clk) begin
    if (st == S_IN && p_v) begin
      dq[p_pos] <= qn;
      da[p_pos] <= p_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cid <= '0; deg <= '0; in_cnt <= '0; first <= 1'b0;
      pf <= 1'b0; p_v <= 1'b0; p_pos <= '0; p_addr <= '0; out_cnt <= '0;
      idx <= '0; min1 <= '1; min2 <= '1; sx <= 1'b0; om1 <= '0; om2 <= '0;
    end else begin
      pf  <= (st == S_IDLE) && cn_start;
      p_v <= acc;
      if (pf) begin
        om1 <= rd_a;
        om2 <= rd_b;
      end
      if (acc) begin
        p_pos  <= in_cnt[PW-1:0];
        p_addr <= edge_var;
        in_cnt <= in_cnt + 1'b1;
      end
      case (st)
        S_IDLE: if (cn_start) begin
          st <= S_IN; cid <= cn_id; deg <= cn_deg; first <= first_iter;
          in_cnt <= '0; out_cnt <= '0; idx <= '0;
          min1 <= '1; min2 <= '1; sx <= 1'b0;
        end
        S_IN: if (p_v) begin
          sx <= sx ^ qn[W-1];
          if (qmag < min1) begin
            min2 <= min1; min1 <= qmag; idx <= p_pos;
          end else if (qmag < min2) begin
            min2 <= qmag;
          end
          if (DW'(p_pos) + 1'b1 == deg) st <= S_OUT;
        end
        S_OUT: begin
          out_cnt <= out_cnt + 1'b1;
          if (last_out) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready     = (st == S_IDLE);
  assign out_valid = (st == S_OUT);
  assign out_var   = da[out_cnt];
  assign out_msg   = rmsg;
  assign out_llr   = nl;
  assign out_code  = {rsg, sel2};
  assign done      = out_valid && last_out;
endmodule

module layered_cn_unit_chk #(parameter int W = 6) (
  input logic         clk,
  input logic         rst_n,
  input logic         ready,
  input logic         out_valid,
  input logic         done,
  input logic [W-1:0] out_msg,
  input logic [W-1:0] out_llr,
  input logic [1:0]   out_code
);
  localparam logic [W-1:0] NEGMAX = {1'b1, {(W-1){1'b0}}};

  assert_done_in_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);
  assert_ready_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ready && !out_valid));
  assert_out_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> out_valid);
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ready);
  assert_no_negmax_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_msg != NEGMAX && out_llr != NEGMAX));
  assert_code_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_msg != '0) |-> (out_code[1] == out_msg[W-1]));
  assert_out_after_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(ready));
endmodule

bind layered_cn_unit layered_cn_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .out_valid(out_valid), .done(done),
  .out_msg(out_msg), .out_llr(out_llr), .out_code(out_code)
);

// File: tb/layered_cn_unit_tb.sv
module layered_cn_unit_tb;
  localparam int NV = 64, NC = 16, DMAX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 0;
  logic [5:0] ld_addr = '0, ld_llr = '0;
  logic cn_start = 0;
  logic [3:0] cn_id = '0;
  logic [4:0] cn_deg = '0;
  logic first_iter = 0;
  logic edge_valid = 0;
  logic [5:0] edge_var = '0;
  logic ready, out_valid, done;
  logic [5:0] out_var, out_msg, out_llr;
  logic [1:0] out_code;

  always #4 clk = ~clk;

  layered_cn_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_llr(ld_llr),
    .cn_start(cn_start), .cn_id(cn_id), .cn_deg(cn_deg), .first_iter(first_iter),
    .edge_valid(edge_valid), .edge_var(edge_var), .ready(ready), .out_valid(out_valid),
    .out_var(out_var), .out_msg(out_msg), .out_llr(out_llr), .out_code(out_code), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  int llr_m [NV];
  int m1_m [NC];
  int m2_m [NC];
  int code_m [NC][DMAX];

  function automatic int sat(int x);
    if (x > 31) return 31;
    if (x < -31) return -31;
    return x;
  endfunction

  function automatic int s6(logic [5:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(int a, int v);
    @(negedge clk);
    ld_en = 1; ld_addr = 6'(a); ld_llr = 6'(v);
    llr_m[a] = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  // Runs one check node through the DUT and through the behavioural model.
  task automatic run_cn(int cid, int deg, int base, int stride, bit first, int gap);
    int vars [DMAX];
    int q [DMAX];
    int e_msg [DMAX];
    int e_llr [DMAX];
    int e_code [DMAX];
    int m1, m2, ix, sx;
    int wd;
    m1 = 31; m2 = 31; ix = 0; sx = 0;
    for (int k = 0; k < deg; k++) begin
      int old, c, mg;
      vars[k] = (base + k*stride) % NV;
      if (first) old = 0;
      else begin
        c  = code_m[cid][k];
        mg = (c & 1) ? m2_m[cid] : m1_m[cid];
        old = (c & 2) ? -mg : mg;
      end
      q[k] = sat(llr_m[vars[k]] - old);
      if (q[k] < 0) sx ^= 1;
      begin
        int a;
        a = (q[k] < 0) ? -q[k] : q[k];
        if (a < m1) begin m2 = m1; m1 = a; ix = k; end
        else if (a < m2) m2 = a;
      end
    end
    for (int k = 0; k < deg; k++) begin
      int mg, sg;
      mg = (k == ix) ? m2 : m1;
      sg = sx ^ ((q[k] < 0) ? 1 : 0);
      e_msg[k]  = sg ? -mg : mg;
      e_llr[k]  = sat(q[k] + e_msg[k]);
      e_code[k] = sg*2 + ((k == ix) ? 1 : 0);
    end
    wd = 0;
    while (!ready && wd < 100) begin @(negedge clk); wd++; end
    chk("R7", "ready before start", int'(ready), 1);
    cn_start = 1; cn_id = 4'(cid); cn_deg = 5'(deg); first_iter = first;
    @(negedge clk);
    cn_start = 0;
    for (int k = 0; k < deg; k++) begin
      if (k == gap) begin
        edge_valid = 0;
        cn_start = 1; cn_id = 4'(15); cn_deg = 5'(2);   // R7: stray start while busy
        @(negedge clk);
        cn_start = 0;
        chk("R7", "ready low during stall", int'(ready), 0);
      end
      edge_valid = 1; edge_var = 6'(vars[k]);
      @(negedge clk);
    end
    edge_valid = 0;
    chk("R6", "no output one cycle after last edge", int'(out_valid), 0);
    @(negedge clk);
    for (int k = 0; k < deg; k++) begin
      chk("R6", "out_valid", int'(out_valid), 1);
      chk("R6", "out_var order", int'(out_var), vars[k]);
      chk("R3", "out_msg", s6(out_msg), e_msg[k]);
      chk("R4", "out_code", int'(out_code), e_code[k]);
      chk("R5", "out_llr", s6(out_llr), e_llr[k]);
      chk("R6", "done", int'(done), (k == deg-1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R6", "ready after done", int'(ready), 1);
    chk("R6", "out_valid low after done", int'(out_valid), 0);
    for (int k = 0; k < deg; k++) begin
      llr_m[vars[k]] = e_llr[k];
      code_m[cid][k] = e_code[k];
    end
    m1_m[cid] = m1; m2_m[cid] = m2;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8*150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ready", int'(ready), 1);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) load(i, ((i*37 + 11) % 63) - 31);
    // tie of smallest magnitude (R3)
    load(48, 5); load(49, -5); load(50, 9); load(51, 20);
    // positive saturation (R5, R9)
    load(52, 31); load(53, 25); load(54, 28);
    // negative saturation (R5, R9)
    load(56, -31); load(57, -20);

    for (int it = 0; it < 2; it++) begin
      bit f;
      f = (it == 0);   // R2 first pass, R8 second pass
      run_cn(5, 4, 48, 1, f, -1);
      run_cn(6, 3, 52, 1, f, -1);
      run_cn(7, 2, 56, 1, f, -1);   // R10 minimum degree
      run_cn(0, 4, 0, 1, f, -1);
      run_cn(1, 6, 2, 5, f, 3);     // shares variables with check 0, stall at edge 3
      run_cn(2, 16, 7, 3, f, -1);   // R10 maximum degree
      run_cn(3, 2, 20, 7, f, -1);
    end
    finish_run();
  end
endmodule